// File: doc/BRIEF.md
# Strided Vector Load Unit

This block runs one vector load. It takes a base word address, a stride and a requested element count. It walks the element addresses in order and spreads them over a set of low-order interleaved memory banks. The bank is the low bits of the word address and the row inside that bank is the remaining high bits. Each bank stays occupied for a fixed number of cycles after it accepts an access. When the next element maps to a bank that is still occupied, the unit holds that element back and counts the lost cycle.

A start pulse launches a load, and a done pulse marks its end. Requests go out on a one-hot request vector with a shared row address. The bank models answer one cycle after a request, and each answer is passed to an element write port together with the index of its element. The stall counter lets a test compare the lost cycles against the rule that relates the stride to the bank count. The address generation that produces base and stride, store traffic and caching all belong to other blocks.

Top module: `vecLoadUnit`

## Requirements
- R1: Element k has the word address base + k*stride, taken modulo 2^16. The element goes to bank (address mod 16), which is the low 4 bits of the address, and bankWordAddr carries address/16 (the upper 12 bits) in the cycle of the request.
- R2: At most one bit of bankReq is high in any cycle, and elements are requested strictly in ascending index order, only while busy is high.
- R3: A bank that accepts a request in cycle t takes no other request before cycle t+4. Element k is requested in cycle max(t(k-1)+1, tBank+4), where tBank is the last request cycle of its bank, and element 0 is requested no earlier than the cycle after start.
- R4: stallCount is cleared when a load starts. It rises by one in every cycle in which the pending element waits on a busy bank, and it holds its value while the unit is idle. A stride that is coprime to 16 gives a count of 0.
- R5: The number of requests equals vecLen when vecLen is at most 64, and equals 64 when vecLen is larger. A vecLen of 0 issues no request.
- R6: Data that a bank returns in the cycle after a request appears on the write port in that same cycle, with wrIdx equal to the element index. Each element is written exactly once.
- R7: done is a one-cycle pulse two cycles after the last request, which is one cycle after the last write. For vecLen 0 it comes one cycle after start. busy is high from the cycle after start through the done cycle and low afterwards.
- R8: A start pulse while busy is high is ignored, and the running load keeps its addresses, count and timing.
- R9: A stride of 0 sends every element to one bank, which gives stallCount = 3*(n-1) for n elements.
- R10: After reset, bankReq, wrEn, busy and done are 0, and stallCount is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a load (sampled while idle) |
| baseAddr | input | 16 | Word address of element 0 |
| stride | input | 16 | Word distance between adjacent elements |
| vecLen | input | 7 | Requested element count (clamped to 64) |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle end-of-load pulse |
| bankReq | output | 16 | One-hot bank request |
| bankWordAddr | output | 12 | Row address inside the requested bank |
| bankRdValid | input | 16 | Per-bank read data valid |
| bankRdData | input | 256 | Per-bank read data, bank b at bits [16b+15:16b] |
| wrEn | output | 1 | Element write strobe |
| wrIdx | output | 6 | Element index of the write |
| wrData | output | 16 | Element data |
| stallCount | output | 16 | Bank-conflict cycles of the current or last load |

## Verification
Element 0 may be requested in the cycle after start at the earliest. Every later request falls in the cycle that a bench-side bank occupancy model predicts, and each write lands one cycle after its request. done follows two cycles after the last request, or one cycle after start for an empty load. The bench records the cycle of every request, write and done pulse at the falling edge and compares those cycle numbers with the model, not with a fixed wait. stallCount is compared against both the model and a hand-derived value from the stride-to-bank relation, and it is read a few cycles after done to confirm that it stays stable.

// File: rtl/vlu_pkg.sv
package vlu_pkg;

  typedef struct packed {
    logic load;
    logic issue;
    logic stall;
  } vluStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_FIN   = 2'd3
  } vluState_t;

endpackage

// File: rtl/vluBankTracker.sv
module vluBankTracker #(
  parameter int NUM_BANKS = 16,
  parameter int BANK_W    = 4,
  parameter int BUSY_CYC  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 issue,
  input  logic [BANK_W-1:0]    issueBank,
  output logic [NUM_BANKS-1:0] bankIdle
);

  localparam int CNT_W = (BUSY_CYC > 1) ? $clog2(BUSY_CYC) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(BUSY_CYC - 1);

  // one occupancy counter per bank; zero means the bank takes a request
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic [CNT_W-1:0] occCnt;

    always_ff @(posedge clk) begin
      if (rst) begin
        occCnt <= '0;
      end else if (issue && (issueBank == BANK_W'(g))) begin
        occCnt <= RELOAD;
      end else if (occCnt != '0) begin
        occCnt <= occCnt - 1'b1;
      end
    end

    assign bankIdle[g] = (occCnt == '0);
  end

endmodule

// File: rtl/vluControl.sv
module vluControl
  import vlu_pkg::*;
#(
  parameter int MAX_VL = 64,
  parameter int IDX_W  = 6,
  parameter int VLEN_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [VLEN_W-1:0] vecLen,
  input  logic              bankFree,
  output vluStrobe_t        strobe,
  output logic [IDX_W-1:0]  elemIdx,
  output logic              busy,
  output logic              done
);

  vluState_t stateQ, stateD;
  logic [IDX_W-1:0]  elemIdxQ;
  logic [IDX_W-1:0]  lastIdxQ;
  logic [VLEN_W-1:0] vlenEff;

  assign vlenEff = (vecLen > VLEN_W'(MAX_VL)) ? VLEN_W'(MAX_VL) : vecLen;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    case (stateQ)
      ST_IDLE: begin
        if (start) begin
          strobe.load = 1'b1;
          stateD = (vlenEff == '0) ? ST_FIN : ST_RUN;
        end
      end
      ST_RUN: begin
        if (bankFree) begin
          strobe.issue = 1'b1;
          if (elemIdxQ == lastIdxQ) stateD = ST_DRAIN;
        end else begin
          strobe.stall = 1'b1;
        end
      end
      ST_DRAIN: stateD = ST_FIN;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ   <= ST_IDLE;
      elemIdxQ <= '0;
      lastIdxQ <= '0;
    end else begin
      stateQ <= stateD;
      if (strobe.load) begin
        elemIdxQ <= '0;
        lastIdxQ <= IDX_W'(vlenEff - 1'b1);
      end else if (strobe.issue) begin
        elemIdxQ <= elemIdxQ + 1'b1;
      end
    end
  end

  assign elemIdx = elemIdxQ;
  assign busy    = (stateQ != ST_IDLE);
  assign done    = (stateQ == ST_FIN);

endmodule

// File: rtl/vluDatapath.sv
module vluDatapath
  import vlu_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int NUM_BANKS = 16,
  parameter int BANK_W    = 4,
  parameter int BUSY_CYC  = 4,
  parameter int IDX_W     = 6,
  parameter int STALL_W   = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  vluStrobe_t                  strobe,
  input  logic [IDX_W-1:0]            elemIdx,
  input  logic [ADDR_W-1:0]           baseAddr,
  input  logic [ADDR_W-1:0]           stride,
  input  logic [NUM_BANKS-1:0]        bankRdValid,
  input  logic [NUM_BANKS*DATA_W-1:0] bankRdData,
  output logic                        bankFree,
  output logic [NUM_BANKS-1:0]        bankReq,
  output logic [ADDR_W-BANK_W-1:0]    bankWordAddr,
  output logic                        wrEn,
  output logic [IDX_W-1:0]            wrIdx,
  output logic [DATA_W-1:0]           wrData,
  output logic [STALL_W-1:0]          stallCount
);

  logic [ADDR_W-1:0]    addrQ;
  logic [ADDR_W-1:0]    strideQ;
  logic [BANK_W-1:0]    curBank;
  logic [NUM_BANKS-1:0] bankIdle;
  logic                 pendValidQ;
  logic [BANK_W-1:0]    pendBankQ;
  logic [IDX_W-1:0]     pendIdxQ;
  logic [STALL_W-1:0]   stallQ;

  assign curBank      = addrQ[BANK_W-1:0];
  assign bankWordAddr = addrQ[ADDR_W-1:BANK_W];
  assign bankFree     = bankIdle[curBank];
  assign bankReq      = strobe.issue ? (NUM_BANKS'(1) << curBank) : '0;

  vluBankTracker #(
    .NUM_BANKS(NUM_BANKS),
    .BANK_W   (BANK_W),
    .BUSY_CYC (BUSY_CYC)
  ) u_tracker (
    .clk      (clk),
    .rst      (rst),
    .issue    (strobe.issue),
    .issueBank(curBank),
    .bankIdle (bankIdle)
  );

  // address walk and stall accounting
  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ   <= '0;
      strideQ <= '0;
      stallQ  <= '0;
    end else begin
      if (strobe.load) begin
        addrQ   <= baseAddr;
        strideQ <= stride;
        stallQ  <= '0;
      end else begin
        if (strobe.issue) addrQ  <= addrQ + strideQ;
        if (strobe.stall) stallQ <= stallQ + 1'b1;
      end
    end
  end

  // remember which bank and element the single outstanding answer belongs to
  always_ff @(posedge clk) begin
    if (rst) begin
      pendValidQ <= 1'b0;
      pendBankQ  <= '0;
      pendIdxQ   <= '0;
    end else begin
      pendValidQ <= strobe.issue;
      if (strobe.issue) begin
        pendBankQ <= curBank;
        pendIdxQ  <= elemIdx;
      end
    end
  end

  assign wrEn       = pendValidQ & bankRdValid[pendBankQ];
  assign wrIdx      = pendIdxQ;
  assign wrData     = bankRdData[int'(pendBankQ)*DATA_W +: DATA_W];
  assign stallCount = stallQ;

endmodule

// File: rtl/vecLoadUnit.sv
module vecLoadUnit
  import vlu_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int NUM_BANKS = 16,
  parameter int BUSY_CYC  = 4,
  parameter int MAX_VL    = 64,
  parameter int STALL_W   = 16,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int IDX_W    = $clog2(MAX_VL),
  localparam int VLEN_W   = IDX_W + 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic [ADDR_W-1:0]           baseAddr,
  input  logic [ADDR_W-1:0]           stride,
  input  logic [VLEN_W-1:0]           vecLen,
  output logic                        busy,
  output logic                        done,
  output logic [NUM_BANKS-1:0]        bankReq,
  output logic [ADDR_W-BANK_W-1:0]    bankWordAddr,
  input  logic [NUM_BANKS-1:0]        bankRdValid,
  input  logic [NUM_BANKS*DATA_W-1:0] bankRdData,
  output logic                        wrEn,
  output logic [IDX_W-1:0]            wrIdx,
  output logic [DATA_W-1:0]           wrData,
  output logic [STALL_W-1:0]          stallCount
);

  vluStrobe_t       strobe;
  logic [IDX_W-1:0] elemIdx;
  logic             bankFree;

  vluControl #(
    .MAX_VL(MAX_VL),
    .IDX_W (IDX_W),
    .VLEN_W(VLEN_W)
  ) u_ctl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .vecLen  (vecLen),
    .bankFree(bankFree),
    .strobe  (strobe),
    .elemIdx (elemIdx),
    .busy    (busy),
    .done    (done)
  );

  vluDatapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_BANKS(NUM_BANKS),
    .BANK_W   (BANK_W),
    .BUSY_CYC (BUSY_CYC),
    .IDX_W    (IDX_W),
    .STALL_W  (STALL_W)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .elemIdx     (elemIdx),
    .baseAddr    (baseAddr),
    .stride      (stride),
    .bankRdValid (bankRdValid),
    .bankRdData  (bankRdData),
    .bankFree    (bankFree),
    .bankReq     (bankReq),
    .bankWordAddr(bankWordAddr),
    .wrEn        (wrEn),
    .wrIdx       (wrIdx),
    .wrData      (wrData),
    .stallCount  (stallCount)
  );

endmodule

// File: rtl/vecLoadUnit_chk.sv
module vecLoadUnit_chk #(
  parameter int NUM_BANKS = 16,
  parameter int BUSY_CYC  = 4,
  parameter int STALL_W   = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic [NUM_BANKS-1:0] bankReq,
  input logic                 wrEn,
  input logic [STALL_W-1:0]   stallCount
);

  localparam int SH_W = $clog2(BUSY_CYC + 1);

  p_single_req_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bankReq));

  p_req_in_run_r2: assert property (@(posedge clk) disable iff (rst)
    (|bankReq) |-> busy);

  p_write_follows_req_r6: assert property (@(posedge clk) disable iff (rst)
    wrEn |-> $past(|bankReq));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_stall_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(stallCount));

  // independent occupancy shadow per bank, window counted rather than unrolled
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_rest
    logic [SH_W-1:0] shadow;
    always_ff @(posedge clk) begin
      if (rst)                 shadow <= '0;
      else if (bankReq[g])     shadow <= SH_W'(BUSY_CYC - 1);
      else if (shadow != '0)   shadow <= shadow - 1'b1;
    end
    p_bank_rest_r3: assert property (@(posedge clk) disable iff (rst)
      bankReq[g] |-> (shadow == '0));
  end

endmodule

bind vecLoadUnit vecLoadUnit_chk #(
  .NUM_BANKS(NUM_BANKS),
  .BUSY_CYC (BUSY_CYC),
  .STALL_W  (STALL_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .bankReq   (bankReq),
  .wrEn      (wrEn),
  .stallCount(stallCount)
);

// File: tb/sim_vecLoadUnit.sv
module sim_vecLoadUnit;

  localparam int CLK_PERIOD = 10;
  localparam int NB = 16;
  localparam int DW = 16;

  // {base, stride, vecLen, expected stalls}
  localparam int NVEC = 10;
  localparam logic [54:0] VEC [0:NVEC-1] = '{
    {16'h0000, 16'd1,  7'd64, 16'd0},   // R4 coprime, full length
    {16'h0005, 16'd3,  7'd20, 16'd0},   // R4 coprime
    {16'h0100, 16'd8,  7'd64, 16'd62},  // two banks alternate
    {16'h0007, 16'd0,  7'd10, 16'd27},  // R9 stride zero
    {16'h0000, 16'd16, 7'd5,  16'd12},  // same bank, nonzero stride
    {16'h0003, 16'd2,  7'd33, 16'd0},   // revisit after 8
    {16'hFFF0, 16'd5,  7'd40, 16'd0},   // address wrap, R1
    {16'h0001, 16'd4,  7'd17, 16'd0},   // revisit after exactly 4
    {16'h0002, 16'd12, 7'd9,  16'd0},   // revisit after 4
    {16'h0000, 16'd24, 7'd8,  16'd6}    // revisit after 2
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [15:0] baseAddr = '0;
  logic [15:0] stride = '0;
  logic [6:0]  vecLen = '0;
  logic busy, done, wrEn;
  logic [NB-1:0] bankReq;
  logic [11:0] bankWordAddr;
  logic [NB-1:0] bankRdValid;
  logic [NB*DW-1:0] bankRdData;
  logic [5:0] wrIdx;
  logic [15:0] wrData, stallCount;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  bit logOn = 0;
  int nReq, nWr, nDone, doneCyc;
  int reqCyc [0:127];
  int reqAddr [0:127];
  int reqIdxOrder;
  logic [15:0] bufMem [0:63];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vecLoadUnit u0 (
    .clk(clk), .rst(rst), .start(start), .baseAddr(baseAddr), .stride(stride),
    .vecLen(vecLen), .busy(busy), .done(done), .bankReq(bankReq),
    .bankWordAddr(bankWordAddr), .bankRdValid(bankRdValid), .bankRdData(bankRdData),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData), .stallCount(stallCount)
  );

  // bank models: answer one cycle after a request with the full word address
  always @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (rst) bankRdValid[b] <= 1'b0;
      else     bankRdValid[b] <= bankReq[b];
      if (bankReq[b]) bankRdData[b*DW +: DW] <= {bankWordAddr, 4'(b)};
    end
  end

  // observe away from the active edge
  always @(negedge clk) begin
    if (logOn) begin
      if (|bankReq && nReq < 128) begin
        int bk;
        bk = 0;
        for (int b = 0; b < NB; b++) if (bankReq[b]) bk = b;
        reqCyc[nReq]  = cyc;
        reqAddr[nReq] = {bankWordAddr, 4'(bk)};
        nReq++;
      end
      if (wrEn) begin
        if (int'(wrIdx) != reqIdxOrder) reqIdxOrder = -1000;
        else reqIdxOrder++;
        bufMem[wrIdx] = wrData;
        nWr++;
      end
      if (done) begin
        doneCyc = cyc;
        nDone++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runLoad(input logic [15:0] b, input logic [15:0] s, input logic [6:0] vl,
                         input int expStall, input bit glitch);
    int S, n, t, tLast, badAddr, badTime, badBuf, waitN;
    int lastUse [0:15];
    logic [15:0] a;
    nReq = 0; nWr = 0; nDone = 0; doneCyc = -1; reqIdxOrder = 0;
    for (int k = 0; k < 64; k++) bufMem[k] = 16'hDEAD;
    @(negedge clk);
    start = 1'b1; baseAddr = b; stride = s; vecLen = vl;
    S = cyc;
    logOn = 1;
    @(negedge clk);
    start = 1'b0;
    if (glitch) begin
      repeat (2) @(negedge clk);
      start = 1'b1; baseAddr = b + 16'd1; stride = s + 16'd1; vecLen = 7'd3;
      @(negedge clk);
      start = 1'b0;
    end
    waitN = 0;
    while (nDone == 0 && waitN < 2000) begin
      @(negedge clk);
      waitN++;
    end
    repeat (4) @(negedge clk);
    logOn = 0;
    check(nDone == 1, "R7 done pulse count / watchdog", nDone, 1);

    n = (vl > 7'd64) ? 64 : int'(vl);
    for (int q = 0; q < 16; q++) lastUse[q] = -100;
    t = S; badAddr = 0; badTime = 0; badBuf = 0;
    for (int k = 0; k < n; k++) begin
      a = b + 16'(k) * s;
      t = (t + 1 > lastUse[a[3:0]] + 4) ? t + 1 : lastUse[a[3:0]] + 4;
      lastUse[a[3:0]] = t;
      if (k < nReq) begin
        if (reqAddr[k] != int'(a)) badAddr++;
        if (reqCyc[k] != t) badTime++;
      end
      if (bufMem[k] != a) badBuf++;
    end
    tLast = t;
    check(nReq == n, "R5 request count", nReq, n);
    check(badAddr == 0, "R1 element addresses", badAddr, 0);
    check(badTime == 0, "R3 request cycles", badTime, 0);
    check(badBuf == 0 && nWr == n, "R6 buffer contents", badBuf, 0);
    check(reqIdxOrder == n, "R2 write order", reqIdxOrder, n);
    check(doneCyc == ((n == 0) ? S + 1 : tLast + 2), "R7 done cycle", doneCyc - S,
          (n == 0) ? 1 : tLast + 2 - S);
    check(int'(stallCount) == ((n == 0) ? 0 : tLast - S - n), "R4 stall vs model",
          int'(stallCount), (n == 0) ? 0 : tLast - S - n);
    check(int'(stallCount) == expStall, "R4 stall vs stride rule", int'(stallCount), expStall);
    check(busy == 1'b0, "R7 busy after done", int'(busy), 0);
    if (glitch)
      check(badAddr == 0 && nReq == n && badTime == 0, "R8 start while busy ignored",
            badAddr + badTime, 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(bankReq == '0, "R10 no request", int'(bankReq), 0);
    check(!busy && !done && !wrEn, "R10 idle flags", int'({busy, done, wrEn}), 0);
    check(stallCount == '0, "R10 stall count", int'(stallCount), 0);

    for (int v = 0; v < NVEC; v++)
      runLoad(VEC[v][54:39], VEC[v][38:23], VEC[v][22:16], int'(VEC[v][15:0]), 1'b0);

    // R5 empty load and clamp
    runLoad(16'h0040, 16'd1, 7'd0, 0, 1'b0);
    runLoad(16'h0000, 16'd1, 7'd100, 0, 1'b0);
    // R9 stride zero with a single element and a longer run
    runLoad(16'h0123, 16'd0, 7'd1, 0, 1'b0);
    runLoad(16'h0009, 16'd0, 7'd30, 87, 1'b0);
    // R8 start pulse during a stalled load
    runLoad(16'h0010, 16'd16, 7'd12, 33, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule